// File: doc/BRIEF.md
# SCSI DMA Byte/Word FIFO Bridge

This block sits between the 8-bit data port of a SCSI bus controller and a 16-bit DMA master. Received bytes are paired into words for the DMA side. Words fetched by the DMA side are split back into bytes for sending. A word FIFO holds the data in between. A host register port gives access to a control/status word, a byte counter and a read-only view of the FIFO data.

Software loads the byte counter while the bus is still in a non-data phase. It picks the direction, releases the FIFO, and then lets the controller and the DMA engine run. When the transfer ends, software reads the counter to get the residue. After a receive it can recover any bytes the DMA engine did not drain by reading the FIFO data view. The control word also holds two active-low reset bits: one for the FIFO and one for the attached SCSI controller. Two sticky error flags and an interrupt output are in the status part of the same word.

Top module: `sdma_bridge`

## Requirements
- R1: Register addresses are 0 for control/status, 1 for the byte counter and 2 for the FIFO data view. Control bits are: bit 0 = FIFO run, bit 1 = SCSI run, bit 2 = send, bit 3 = interrupt enable. Status bits are: bit 8 = FIFO empty, bit 9 = DMA conflict, bit 10 = DMA bus error, bit 11 = done, bit 12 = interrupt. After reset the control/status word reads 0x0100. `scsi_rst_o` is high while bit 1 is 0. While bit 0 is 0, `s_drq` and `dma_req` stay low.
- R2: A write to the byte counter is ignored while `phase` is 3'b000 (data out) or 3'b001 (data in). In any other phase the write loads the counter.
- R3: Writing bit 0 low and then high empties the word FIFO and drops any held byte. It leaves the byte counter unchanged.
- R4: The counter drops by one for each byte moved on the SCSI side (`s_drq` and `s_dack` both high). It reads back at address 1. `s_drq` stays low while the counter is zero. The done bit sets when the last byte moves. The done bit clears on a counter load or while the FIFO is held in reset.
- R5: When receiving, the first byte of each pair lands in bits 15:8 and the second in bits 7:0. `dma_req` is raised only once a full word is stored.
- R6: When sending, each word yields its bits 15:8 first. An odd count makes the DMA side fetch one extra word (ceil(n/2) fetches in total), and the unused lower half of that word is discarded.
- R7: After a receive with an odd count and no stored words, the data view reads the leftover byte in bits 15:8, with bits 7:0 zero.
- R8: While a stored word has not been drained, the data view returns that word (first byte in 15:8) and the empty bit reads 0.
- R9: The DMA conflict and bus-error flags are set by their input pulses. They stay set until the FIFO is held in reset.
- R10: `irq` is high exactly when interrupt enable is set and at least one of conflict, bus error or done is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase | input | 3 | Current SCSI bus phase |
| reg_we | input | 1 | Host register write strobe |
| reg_addr | input | 2 | Host register address |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Host read data for the addressed register |
| s_drq | output | 1 | Bridge can take (receive) or supply (send) a byte |
| s_dack | input | 1 | Controller moves a byte this cycle |
| s_din | input | 8 | Byte from the controller |
| s_dout | output | 8 | Byte to the controller |
| dma_req | output | 1 | Bridge wants a word moved on the DMA side |
| dma_ack | input | 1 | DMA side moves a word this cycle |
| dma_wdata | input | 16 | Word fetched from memory (send) |
| dma_rdata | output | 16 | Word to memory (receive) |
| dma_conflict_i | input | 1 | DMA conflict pulse |
| dma_bus_err_i | input | 1 | DMA bus error pulse |
| scsi_rst_o | output | 1 | Reset to the SCSI controller, active high |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the direction bit does not change while data is still in flight. They also assume that the controller and the DMA engine raise `s_dack` and `dma_ack` only in a cycle where the matching request is high. The stimulus changes direction only after a FIFO reset. It raises each acknowledge for a single cycle, and only after it has seen the request high at the preceding falling edge. Counter writes in data phases are attempted only with no byte in motion, so the lock can be observed on its own.

// File: rtl/sdma_bridge_pkg.sv
package sdma_bridge_pkg;
  localparam logic [1:0] RA_CSR  = 2'd0;
  localparam logic [1:0] RA_CNT  = 2'd1;
  localparam logic [1:0] RA_DATA = 2'd2;

  localparam logic [2:0] PH_DOUT = 3'b000;
  localparam logic [2:0] PH_DIN  = 3'b001;

  localparam int SB_EMPTY    = 8;
  localparam int SB_CONFLICT = 9;
  localparam int SB_BUSERR   = 10;
  localparam int SB_DONE     = 11;
  localparam int SB_IRQ      = 12;

  typedef struct packed {
    logic ien;
    logic send;
    logic scsi_run;
    logic fifo_run;
  } ctrl_t;

  function automatic logic is_data_phase(input logic [2:0] ph);
    return (ph == PH_DOUT) || (ph == PH_DIN);
  endfunction
endpackage

// File: rtl/sdma_word_fifo.sv
module sdma_word_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4096
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int LW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [LW-1:0] lvl_q, lvl_d;
  logic          do_push, do_pop;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    lvl_d = lvl_q;
    if (clr) begin
      wr_d  = '0;
      rd_d  = '0;
      lvl_d = '0;
    end else begin
      if (do_push) wr_d = wr_q + 1'b1;
      if (do_pop)  rd_d = rd_q + 1'b1;
      if (do_push && !do_pop)      lvl_d = lvl_q + 1'b1;
      else if (do_pop && !do_push) lvl_d = lvl_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      lvl_q <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !clr) mem[wr_q] <= wdata;
  end
endmodule

// File: rtl/sdma_rx_packer.sv
module sdma_rx_packer (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        byte_vld,
  input  logic [7:0]  byte_in,
  output logic        word_vld,
  output logic [15:0] word_out,
  output logic        hold_vld,
  output logic [7:0]  hold_byte
);
  logic       hv_q, hv_d;
  logic [7:0] hb_q, hb_d;
  logic       hb_en;

  assign word_vld  = byte_vld && hv_q;
  assign word_out  = {hb_q, byte_in};
  assign hold_vld  = hv_q;
  assign hold_byte = hb_q;
  assign hb_en     = byte_vld && !hv_q && !clr;

  always_comb begin
    hv_d = hv_q;
    hb_d = hb_q;
    if (clr) begin
      hv_d = 1'b0;
    end else if (byte_vld) begin
      hv_d = !hv_q;
      if (hb_en) hb_d = byte_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_q <= 1'b0;
      hb_q <= '0;
    end else begin
      hv_q <= hv_d;
      if (hb_en) hb_q <= hb_d;
    end
  end
endmodule

// File: rtl/sdma_tx_unpacker.sv
module sdma_tx_unpacker (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic [15:0] head,
  input  logic        byte_take,
  input  logic        last_byte,
  output logic [7:0]  byte_out,
  output logic        word_done
);
  logic lo_q, lo_d;

  assign byte_out  = lo_q ? head[7:0] : head[15:8];
  assign word_done = byte_take && (lo_q || last_byte);

  always_comb begin
    lo_d = lo_q;
    if (clr)            lo_d = 1'b0;
    else if (word_done) lo_d = 1'b0;
    else if (byte_take) lo_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lo_q <= 1'b0;
    else        lo_q <= lo_d;
  end
endmodule

// File: rtl/sdma_xfer_counter.sv
module sdma_xfer_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             byte_step,
  input  logic             word_step,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] fetch_left,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q, cnt_d, fch_q, fch_d;
  logic             dn_q, dn_d;
  logic [CNT_W-1:0] words_needed;

  assign words_needed = {1'b0, load_val[CNT_W-1:1]} + CNT_W'(load_val[0]);

  always_comb begin
    cnt_d = cnt_q;
    fch_d = fch_q;
    dn_d  = dn_q;
    if (load) begin
      cnt_d = load_val;
      fch_d = words_needed;
      dn_d  = 1'b0;
    end else begin
      if (byte_step && cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) dn_d = 1'b1;
      end
      if (word_step && fch_q != '0) fch_d = fch_q - 1'b1;
      if (clr) dn_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      fch_q <= '0;
      dn_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      fch_q <= fch_d;
      dn_q  <= dn_d;
    end
  end

  assign count      = cnt_q;
  assign fetch_left = fch_q;
  assign done       = dn_q;
endmodule

// File: rtl/sdma_bridge.sv
module sdma_bridge
  import sdma_bridge_pkg::*;
#(
  parameter int FIFO_WORDS = 4096,
  parameter int CNT_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  phase,
  input  logic        reg_we,
  input  logic [1:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        s_drq,
  input  logic        s_dack,
  input  logic [7:0]  s_din,
  output logic [7:0]  s_dout,
  output logic        dma_req,
  input  logic        dma_ack,
  input  logic [15:0] dma_wdata,
  output logic [15:0] dma_rdata,
  input  logic        dma_conflict_i,
  input  logic        dma_bus_err_i,
  output logic        scsi_rst_o,
  output logic        irq
);
  localparam int REG_W = 16;
  localparam int CW    = $bits(ctrl_t);

  ctrl_t            ctrl_q, ctrl_d;
  logic             ctrl_we;
  logic             conf_q, conf_d, berr_q, berr_d;
  logic             fifo_clr;
  logic             byte_mv, word_mv;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt, fetch_left;
  logic             done;
  logic             f_push, f_pop, f_empty, f_full;
  logic [15:0]      f_wdata, f_head;
  logic             pk_word_vld, pk_hold_vld;
  logic [15:0]      pk_word;
  logic [7:0]       pk_hold;
  logic             up_pop;
  logic [REG_W-1:0] csr_view, data_view;

  // control and sticky error registers
  assign ctrl_we  = reg_we && (reg_addr == RA_CSR);
  assign fifo_clr = !ctrl_q.fifo_run;
  assign cnt_load = reg_we && (reg_addr == RA_CNT) && !is_data_phase(phase);

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_t'(reg_wdata[CW-1:0]);
    conf_d = fifo_clr ? 1'b0 : (conf_q || dma_conflict_i);
    berr_d = fifo_clr ? 1'b0 : (berr_q || dma_bus_err_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      conf_q <= 1'b0;
      berr_q <= 1'b0;
    end else begin
      if (ctrl_we) ctrl_q <= ctrl_d;
      conf_q <= conf_d;
      berr_q <= berr_d;
    end
  end

  // handshakes
  always_comb begin
    if (ctrl_q.send) begin
      s_drq   = ctrl_q.fifo_run && (cnt != '0) && !f_empty;
      dma_req = ctrl_q.fifo_run && (fetch_left != '0) && !f_full;
    end else begin
      s_drq   = ctrl_q.fifo_run && (cnt != '0) && !f_full;
      dma_req = ctrl_q.fifo_run && !f_empty;
    end
  end

  assign byte_mv = s_drq && s_dack;
  assign word_mv = dma_req && dma_ack;

  assign f_push  = ctrl_q.send ? word_mv   : pk_word_vld;
  assign f_wdata = ctrl_q.send ? dma_wdata : pk_word;
  assign f_pop   = ctrl_q.send ? up_pop    : word_mv;

  sdma_word_fifo #(.W(16), .DEPTH(FIFO_WORDS)) fifo_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (f_push),
    .wdata (f_wdata),
    .pop   (f_pop),
    .rdata (f_head),
    .empty (f_empty),
    .full  (f_full)
  );

  sdma_rx_packer packer_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .byte_vld  (byte_mv && !ctrl_q.send),
    .byte_in   (s_din),
    .word_vld  (pk_word_vld),
    .word_out  (pk_word),
    .hold_vld  (pk_hold_vld),
    .hold_byte (pk_hold)
  );

  sdma_tx_unpacker unpacker_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .head      (f_head),
    .byte_take (byte_mv && ctrl_q.send),
    .last_byte (cnt == CNT_W'(1)),
    .byte_out  (s_dout),
    .word_done (up_pop)
  );

  sdma_xfer_counter #(.CNT_W(CNT_W)) counter_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (fifo_clr),
    .load       (cnt_load),
    .load_val   (reg_wdata[CNT_W-1:0]),
    .byte_step  (byte_mv),
    .word_step  (word_mv && ctrl_q.send),
    .count      (cnt),
    .fetch_left (fetch_left),
    .done       (done)
  );

  assign dma_rdata  = f_head;
  assign scsi_rst_o = !ctrl_q.scsi_run;
  assign irq        = ctrl_q.ien && (conf_q || berr_q || done);

  // host read views
  always_comb begin
    csr_view              = '0;
    csr_view[CW-1:0]      = ctrl_q;
    csr_view[SB_EMPTY]    = f_empty;
    csr_view[SB_CONFLICT] = conf_q;
    csr_view[SB_BUSERR]   = berr_q;
    csr_view[SB_DONE]     = done;
    csr_view[SB_IRQ]      = irq;
  end

  always_comb begin
    if (!f_empty)                         data_view = f_head;
    else if (!ctrl_q.send && pk_hold_vld) data_view = {pk_hold, 8'h00};
    else                                  data_view = '0;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CSR:  reg_rdata = csr_view;
      RA_CNT:  reg_rdata[CNT_W-1:0] = cnt;
      RA_DATA: reg_rdata = data_view;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sdma_bridge_chk.sv
module sdma_bridge_chk
  import sdma_bridge_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [2:0]       phase,
  input logic             reg_we,
  input logic [1:0]       reg_addr,
  input logic             s_drq,
  input logic             s_dack,
  input logic             dma_req,
  input logic             irq,
  input logic [CNT_W-1:0] cnt,
  input logic             fifo_run,
  input logic             send,
  input logic             ien,
  input logic             fifo_full,
  input logic             err_bus
);
  p_idle_in_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fifo_run |-> (!s_drq && !dma_req));

  p_count_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == RA_CNT && is_data_phase(phase) && !(s_drq && s_dack))
      |=> $stable(cnt));

  p_reset_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_run && !(reg_we && reg_addr == RA_CNT)) |=> $stable(cnt));

  p_no_drq_at_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |-> !s_drq);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!send && fifo_full) |-> !s_drq);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_run && err_bus) |=> err_bus);

  p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ien);
endmodule

bind sdma_bridge sdma_bridge_chk #(.CNT_W(CNT_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .phase     (phase),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .s_drq     (s_drq),
  .s_dack    (s_dack),
  .dma_req   (dma_req),
  .irq       (irq),
  .cnt       (cnt),
  .fifo_run  (ctrl_q.fifo_run),
  .send      (ctrl_q.send),
  .ien       (ctrl_q.ien),
  .fifo_full (f_full),
  .err_bus   (berr_q)
);

// File: tb/sdma_bridge_tb.sv
module sdma_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  phase = 3'b010;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        s_drq, s_dack = 1'b0;
  logic [7:0]  s_din = '0, s_dout;
  logic        dma_req, dma_ack = 1'b0;
  logic [15:0] dma_wdata = '0, dma_rdata;
  logic        dma_conflict_i = 1'b0, dma_bus_err_i = 1'b0;
  logic        scsi_rst_o, irq;

  int n_checks = 0;
  int n_err = 0;
  bit finished = 0;

  always #2 clk = !clk;

  sdma_bridge dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic byte_in(input logic [7:0] b);
    @(negedge clk);
    check("R4 drq before byte in", s_drq, 1'b1);
    s_din = b; s_dack = 1'b1;
    @(negedge clk);
    s_dack = 1'b0;
  endtask

  task automatic byte_out(output logic [7:0] b);
    @(negedge clk);
    check("R6 drq before byte out", s_drq, 1'b1);
    b = s_dout; s_dack = 1'b1;
    @(negedge clk);
    s_dack = 1'b0;
  endtask

  task automatic word_in(input logic [15:0] w);
    @(negedge clk);
    check("R6 dma_req before fetch", dma_req, 1'b1);
    dma_wdata = w; dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  task automatic word_out(output logic [15:0] w);
    @(negedge clk);
    check("R5 dma_req before drain", dma_req, 1'b1);
    w = dma_rdata; dma_ack = 1'b1;
    @(negedge clk);
    dma_ack = 1'b0;
  endtask

  task automatic t_reset_state;
    logic [15:0] v;
    @(negedge clk);
    rd(2'd0, v);
    check("R1 csr after reset", v, 16'h0100);
    check("R1 scsi reset held", scsi_rst_o, 1'b1);
    check("R1 no drq in reset", s_drq, 1'b0);
    check("R1 no dma_req in reset", dma_req, 1'b0);
    check("R10 irq after reset", irq, 1'b0);
    wr(2'd0, 16'h0003);
    check("R1 scsi reset released", scsi_rst_o, 1'b0);
  endtask

  task automatic t_count_lock;
    logic [15:0] v;
    phase = 3'b010;
    wr(2'd1, 16'd5);
    rd(2'd1, v);
    check("R2 load in command phase", v, 16'd5);
    phase = 3'b001;
    wr(2'd1, 16'd9);
    rd(2'd1, v);
    check("R2 write ignored in data in", v, 16'd5);
    phase = 3'b000;
    wr(2'd1, 16'd7);
    rd(2'd1, v);
    check("R2 write ignored in data out", v, 16'd5);
    phase = 3'b001;
  endtask

  task automatic t_receive;
    logic [15:0] v, w;
    byte_in(8'h11);
    byte_in(8'h22);
    rd(2'd1, v);
    check("R4 count after two bytes", v, 16'd3);
    rd(2'd0, v);
    check("R8 empty bit clear with word", v[8], 1'b0);
    wr(2'd0, 16'h0002);
    wr(2'd0, 16'h0003);
    rd(2'd0, v);
    check("R3 fifo empty after reset", v[8], 1'b1);
    rd(2'd1, v);
    check("R3 count kept over fifo reset", v, 16'd3);
    byte_in(8'hA1);
    check("R5 no dma_req on half word", dma_req, 1'b0);
    byte_in(8'hB2);
    check("R5 dma_req on full word", dma_req, 1'b1);
    byte_in(8'hC3);
    check("R4 drq low at zero", s_drq, 1'b0);
    rd(2'd1, v);
    check("R4 count reached zero", v, 16'd0);
    rd(2'd0, v);
    check("R4 done bit", v[11], 1'b1);
    rd(2'd2, v);
    check("R8 undrained word in data view", v, 16'hA1B2);
    word_out(w);
    check("R5 packed word order", w, 16'hA1B2);
    rd(2'd0, v);
    check("R8 empty after drain", v[8], 1'b1);
    rd(2'd2, v);
    check("R7 odd leftover in upper byte", v, 16'hC300);
  endtask

  task automatic t_errors_irq;
    logic [15:0] v;
    check("R10 irq off while disabled", irq, 1'b0);
    wr(2'd0, 16'h000B);
    check("R10 irq on done", irq, 1'b1);
    @(negedge clk);
    dma_bus_err_i = 1'b1;
    @(negedge clk);
    dma_bus_err_i = 1'b0;
    phase = 3'b011;
    repeat (3) @(negedge clk);
    rd(2'd0, v);
    check("R9 bus error sticky", v[10], 1'b1);
    check("R9 conflict untouched", v[9], 1'b0);
    @(negedge clk);
    dma_conflict_i = 1'b1;
    @(negedge clk);
    dma_conflict_i = 1'b0;
    rd(2'd0, v);
    check("R9 conflict sticky", v[9], 1'b1);
    wr(2'd0, 16'h000A);
    wr(2'd0, 16'h000B);
    rd(2'd0, v);
    check("R9 errors cleared by fifo reset", v[10:9], 2'b00);
    check("R10 irq cleared", irq, 1'b0);
  endtask

  task automatic t_send_odd;
    logic [15:0] v;
    logic [7:0] b;
    wr(2'd0, 16'h0002);
    wr(2'd0, 16'h0007);
    phase = 3'b010;
    wr(2'd1, 16'd3);
    phase = 3'b000;
    word_in(16'h1122);
    word_in(16'h3344);
    @(negedge clk);
    check("R6 only two fetches for three bytes", dma_req, 1'b0);
    byte_out(b);
    check("R6 first byte upper half", b, 8'h11);
    byte_out(b);
    check("R6 second byte lower half", b, 8'h22);
    byte_out(b);
    check("R6 third byte", b, 8'h33);
    check("R6 drq low after last", s_drq, 1'b0);
    rd(2'd0, v);
    check("R6 unused half discarded", v[8], 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_state();
    t_count_lock();
    t_receive();
    t_errors_irq();
    t_send_odd();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule